// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block takes one vectorised operation at a time and breaks it into scalar element operations for a downstream scalar execution path. An operation carries an opcode, three base register numbers (destination and two sources), a flag per operand saying whether that operand is a vector, a vector length and a predicate bit mask. Only elements whose predicate bit is set and whose index lies below the vector length are sent on. Masked elements are skipped outright: nothing is issued for them and their destination registers are never written, so nothing is zeroed.

Enabled elements are packed onto an issue port of `LANES` scalar lanes, lowest element index first, filling the lanes from lane 0 with no gaps. Whatever cannot go out in one cycle stays in a holding register and goes out in the following cycles until the operation is exhausted. Each lane carries its element index and the resolved register numbers: a vector operand steps its base register by the element index (wrapping within the register file), a scalar operand keeps its base. Both the input and the issue port use a valid/ready handshake.

Top module: `vec_issue_seq`

## Requirements
- R1: After reset, `in_ready` is high and `iss_valid` is low.
- R2: Element i is issued exactly once when i < VL and mask bit i is set (bit 0 is element 0); no other element is issued, and every cycle with `iss_valid` high carries at least one element on lane 0.
- R3: In each issue cycle lane k carries the k-th lowest remaining enabled element; the valid lanes are contiguous from lane 0 and a cycle carries min(LANES, remaining enabled elements).
- R4: The issued destination, source 1 and source 2 numbers equal (base + element index) mod 2^REG_W when that operand's vector flag is set, and the base number otherwise.
- R5: When all three vector flags are clear, exactly one element with index 0 is issued on lane 0, whatever VL and the mask hold.
- R6: An operation with at least one vector flag set and no enabled element (VL of 0, or no mask bit set below VL) issues nothing, and `in_ready` is high in the following cycle.
- R7: `in_ready` is low while elements beyond the group currently offered remain, and high in the cycle the final group is offered with `iss_ready` high, so the next operation is taken in that same cycle.
- R8: While `iss_valid` is high and `iss_ready` is low, the issue outputs hold their values into the next cycle.
- R9: A VL above XLEN is treated as XLEN.
- R10: `iss_op` equals the opcode of the operation being issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation taken when high together with in_valid |
| in_op | input | OP_W | Opcode tag |
| in_rd | input | REG_W | Destination base register |
| in_rs1 | input | REG_W | Source 1 base register |
| in_rs2 | input | REG_W | Source 2 base register |
| in_vrd | input | 1 | Destination is a vector |
| in_vrs1 | input | 1 | Source 1 is a vector |
| in_vrs2 | input | 1 | Source 2 is a vector |
| in_vl | input | $clog2(XLEN+1) | Vector length |
| in_mask | input | XLEN | Predicate mask, bit i enables element i |
| iss_valid | output | 1 | Issue group offered |
| iss_ready | input | 1 | Issue group consumed when high with iss_valid |
| iss_op | output | OP_W | Opcode of the issued elements |
| iss_lane_vld | output | LANES | Per-lane valid |
| iss_idx | output | LANES*$clog2(XLEN) | Element index per lane, lane k at bits k*IDX_W |
| iss_rd | output | LANES*REG_W | Resolved destination per lane |
| iss_rs1 | output | LANES*REG_W | Resolved source 1 per lane |
| iss_rs2 | output | LANES*REG_W | Resolved source 2 per lane |

## Verification
The final group of one operation leaving the issue port and the next operation entering at the input can fall in the same cycle. The bench provokes it by holding a second operation at the input while the last two elements of a six-element operation are offered with `iss_ready` high, checks that `in_ready` was low during the first group and high during the last, and then checks that the very next issue cycle carries the second operation's elements and opcode with no idle cycle between them.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    // Architectural widths shared by every unit of the sequencer
    localparam int REG_W = 5;
    localparam int OP_W  = 8;

    // Operation header kept while its elements are being issued
    typedef struct packed {
        logic [OP_W-1:0]  opc;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic             vrd;
        logic             vrs1;
        logic             vrs2;
    } vop_t;

    // Register number for one element: vector operands step, scalars stay
    function automatic logic [REG_W-1:0] step_reg(
        input logic [REG_W-1:0] base,
        input logic             is_vec,
        input logic [REG_W-1:0] ofs
    );
        return is_vec ? (base + ofs) : base;
    endfunction

    // True when no operand is a vector
    function automatic logic all_scalar(input vop_t op);
        return !(op.vrd || op.vrs1 || op.vrs2);
    endfunction

endpackage

// File: rtl/vseq_lane_pick.sv
module vseq_lane_pick #(
    parameter int LANES = 4,
    parameter int XLEN  = 64,
    localparam int IDX_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]        pend,
    output logic [LANES-1:0]       lane_vld,
    output logic [LANES*IDX_W-1:0] lane_idx,
    output logic [XLEN-1:0]        taken,
    output logic                   last_grp
);

    // Each lane peels off the lowest set bit left by the lanes before it
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [XLEN-1:0]  rem_in;
        logic [XLEN-1:0]  hot;
        logic [XLEN-1:0]  rem_out;
        logic [IDX_W-1:0] enc;

        if (k == 0) begin : g_first
            assign rem_in = pend;
        end else begin : g_next
            assign rem_in = g_lane[k-1].rem_out;
        end

        assign hot     = rem_in & (~rem_in + XLEN'(1));
        assign rem_out = rem_in & ~hot;
        assign lane_vld[k] = |rem_in;

        always_comb begin
            enc = '0;
            for (int b = 0; b < XLEN; b++) begin
                if (hot[b]) enc = IDX_W'(b);
            end
        end

        assign lane_idx[k*IDX_W +: IDX_W] = enc;
    end

    assign taken    = pend & ~g_lane[LANES-1].rem_out;
    assign last_grp = ~|g_lane[LANES-1].rem_out;

endmodule

// File: rtl/vseq_reg_map.sv
module vseq_reg_map
    import vseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IDX_W = 6
) (
    input  vop_t                   op,
    input  logic [LANES*IDX_W-1:0] lane_idx,
    output logic [LANES*REG_W-1:0] rd_o,
    output logic [LANES*REG_W-1:0] rs1_o,
    output logic [LANES*REG_W-1:0] rs2_o
);

    for (genvar k = 0; k < LANES; k++) begin : g_map
        logic [REG_W-1:0] ofs;
        assign ofs = REG_W'(lane_idx[k*IDX_W +: IDX_W]);
        assign rd_o [k*REG_W +: REG_W] = step_reg(op.rd,  op.vrd,  ofs);
        assign rs1_o[k*REG_W +: REG_W] = step_reg(op.rs1, op.vrs1, ofs);
        assign rs2_o[k*REG_W +: REG_W] = step_reg(op.rs2, op.vrs2, ofs);
    end

endmodule

// File: rtl/vseq_hold.sv
module vseq_hold
    import vseq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            adv,
    input  vop_t            load_op,
    input  logic [XLEN-1:0] load_mask,
    input  logic [XLEN-1:0] taken,
    output logic            busy,
    output vop_t            op,
    output logic [XLEN-1:0] pend
);

    logic [XLEN-1:0] left;
    assign left = pend & ~taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pend <= '0;
            op   <= '0;
        end else if (load) begin
            op   <= load_op;
            pend <= load_mask;
            busy <= |load_mask;
        end else if (adv) begin
            pend <= left;
            busy <= |left;
        end
    end

endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
    import vseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int XLEN  = 64,
    localparam int VL_W  = $clog2(XLEN + 1),
    localparam int IDX_W = $clog2(XLEN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [OP_W-1:0]        in_op,
    input  logic [REG_W-1:0]       in_rd,
    input  logic [REG_W-1:0]       in_rs1,
    input  logic [REG_W-1:0]       in_rs2,
    input  logic                   in_vrd,
    input  logic                   in_vrs1,
    input  logic                   in_vrs2,
    input  logic [VL_W-1:0]        in_vl,
    input  logic [XLEN-1:0]        in_mask,
    output logic                   iss_valid,
    input  logic                   iss_ready,
    output logic [OP_W-1:0]        iss_op,
    output logic [LANES-1:0]       iss_lane_vld,
    output logic [LANES*IDX_W-1:0] iss_idx,
    output logic [LANES*REG_W-1:0] iss_rd,
    output logic [LANES*REG_W-1:0] iss_rs1,
    output logic [LANES*REG_W-1:0] iss_rs2
);

    vop_t            new_op;
    vop_t            cur_op;
    logic            busy;
    logic [XLEN-1:0] pend;
    logic [XLEN-1:0] taken;
    logic [XLEN-1:0] eff_mask;
    logic [XLEN-1:0] vl_win;
    logic [VL_W-1:0] vl_c;
    logic            last_grp;
    logic            accept;
    logic            fire;

    assign new_op = '{opc: in_op, rd: in_rd, rs1: in_rs1, rs2: in_rs2,
                      vrd: in_vrd, vrs1: in_vrs1, vrs2: in_vrs2};

    // Clamp the length to the mask width, then open the element window
    assign vl_c = (in_vl > VL_W'(XLEN)) ? VL_W'(XLEN) : in_vl;

    always_comb begin
        vl_win = '0;
        for (int i = 0; i < XLEN; i++) begin
            vl_win[i] = (i < int'(vl_c));
        end
    end

    // All-scalar operations collapse to one unconditional element 0
    assign eff_mask = all_scalar(new_op) ? XLEN'(1) : (in_mask & vl_win);

    assign fire     = iss_valid & iss_ready;
    assign in_ready = ~busy | (iss_ready & last_grp);
    assign accept   = in_valid & in_ready;

    vseq_hold #(.XLEN(XLEN)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (fire),
        .load_op   (new_op),
        .load_mask (eff_mask),
        .taken     (taken),
        .busy      (busy),
        .op        (cur_op),
        .pend      (pend)
    );

    vseq_lane_pick #(.LANES(LANES), .XLEN(XLEN)) u_pick (
        .pend     (pend),
        .lane_vld (iss_lane_vld),
        .lane_idx (iss_idx),
        .taken    (taken),
        .last_grp (last_grp)
    );

    vseq_reg_map #(.LANES(LANES), .IDX_W(IDX_W)) u_map (
        .op       (cur_op),
        .lane_idx (iss_idx),
        .rd_o     (iss_rd),
        .rs1_o    (iss_rs1),
        .rs2_o    (iss_rs2)
    );

    assign iss_valid = busy;
    assign iss_op    = cur_op.opc;

endmodule

// File: rtl/vec_issue_seq_chk.sv
module vec_issue_seq_chk
    import vseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int XLEN  = 64,
    localparam int VL_W  = $clog2(XLEN + 1),
    localparam int IDX_W = $clog2(XLEN)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   in_vrd,
    input logic                   in_vrs1,
    input logic                   in_vrs2,
    input logic [VL_W-1:0]        in_vl,
    input logic                   iss_valid,
    input logic                   iss_ready,
    input logic [LANES-1:0]       iss_lane_vld,
    input logic [LANES*IDX_W-1:0] iss_idx,
    input logic [LANES*REG_W-1:0] iss_rd
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !iss_valid));

    // R2
    lane0_used_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> iss_lane_vld[0]);

    // R6
    empty_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_vl == '0 && (in_vrd || in_vrs1 || in_vrs2))
        |=> (!iss_valid && in_ready));

    // R7
    held_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |-> !in_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_lane_vld)
                                       && $stable(iss_idx) && $stable(iss_rd)));

    for (genvar k = 1; k < LANES; k++) begin : g_ord
        // R3
        lane_order_chk: assert property (@(posedge clk) disable iff (rst)
            iss_lane_vld[k] |-> (iss_lane_vld[k-1] &&
                (iss_idx[k*IDX_W +: IDX_W] > iss_idx[(k-1)*IDX_W +: IDX_W])));
    end

endmodule

bind vec_issue_seq vec_issue_seq_chk #(.LANES(LANES), .XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_vrd       (in_vrd),
    .in_vrs1      (in_vrs1),
    .in_vrs2      (in_vrs2),
    .in_vl        (in_vl),
    .iss_valid    (iss_valid),
    .iss_ready    (iss_ready),
    .iss_lane_vld (iss_lane_vld),
    .iss_idx      (iss_idx),
    .iss_rd       (iss_rd)
);

// File: tb/sim_vec_issue_seq.sv
module sim_vec_issue_seq;
    import vseq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int XLEN  = 8;
    localparam int VL_W  = $clog2(XLEN + 1);
    localparam int IDX_W = $clog2(XLEN);

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [OP_W-1:0]        in_op = '0;
    logic [REG_W-1:0]       in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic                   in_vrd = 1'b0, in_vrs1 = 1'b0, in_vrs2 = 1'b0;
    logic [VL_W-1:0]        in_vl = '0;
    logic [XLEN-1:0]        in_mask = '0;
    logic                   iss_valid;
    logic                   iss_ready = 1'b0;
    logic [OP_W-1:0]        iss_op;
    logic [LANES-1:0]       iss_lane_vld;
    logic [LANES*IDX_W-1:0] iss_idx;
    logic [LANES*REG_W-1:0] iss_rd, iss_rs1, iss_rs2;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_issue_seq #(.LANES(LANES), .XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_vrd(in_vrd), .in_vrs1(in_vrs1), .in_vrs2(in_vrs2),
        .in_vl(in_vl), .in_mask(in_mask), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_op(iss_op), .iss_lane_vld(iss_lane_vld),
        .iss_idx(iss_idx), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lane_idx(input int k);
        return int'(iss_idx[k*IDX_W +: IDX_W]);
    endfunction
    function automatic int lane_reg(input logic [LANES*REG_W-1:0] v, input int k);
        return int'(v[k*REG_W +: REG_W]);
    endfunction
    function automatic int exp_reg(input int base, input bit vec, input int idx);
        return vec ? ((base + idx) % 32) : base;
    endfunction

    task automatic put_inputs(input int op, input int rd, input int rs1, input int rs2,
                              input bit vd, input bit v1, input bit v2,
                              input int vl, input int mask);
        in_op = OP_W'(op); in_rd = REG_W'(rd); in_rs1 = REG_W'(rs1); in_rs2 = REG_W'(rs2);
        in_vrd = vd; in_vrs1 = v1; in_vrs2 = v2;
        in_vl = VL_W'(vl); in_mask = XLEN'(mask);
    endtask

    // Send one operation and drain it; stall inserts a hold on every other cycle
    task automatic run_op(input int op, input int rd, input int rs1, input int rs2,
                          input bit vd, input bit v1, input bit v2,
                          input int vl, input int mask, input bit stall, input string req);
        int el[$];
        int lim;
        int ptr;
        int cyc;
        int n;
        bit prev_stall;
        int snap_idx[LANES];
        int snap_vld;
        lim = (vl > XLEN) ? XLEN : vl;
        if (!(vd || v1 || v2)) el.push_back(0);
        else for (int i = 0; i < lim; i++) if (mask[i]) el.push_back(i);
        n = el.size();
        @(negedge clk);
        put_inputs(op, rd, rs1, rs2, vd, v1, v2, vl, mask);
        in_valid = 1'b1;
        iss_ready = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R7", "in_ready before send", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        ptr = 0; cyc = 0; prev_stall = 1'b0; snap_vld = 0;
        while (ptr < n && cyc < 64) begin
            bit rdy;
            int grp;
            rdy = stall ? ((cyc % 2) == 1) : 1'b1;
            iss_ready = rdy;
            #1;
            grp = (n - ptr < LANES) ? (n - ptr) : LANES;
            chk(iss_valid == 1'b1, req, "iss_valid while elements remain", int'(iss_valid), 1);
            chk(in_ready == (rdy && (n - ptr <= LANES)), "R7", "in_ready during issue",
                int'(in_ready), int'(rdy && (n - ptr <= LANES)));
            chk(int'(iss_op) == (op & 8'hFF), "R10", "opcode", int'(iss_op), op & 8'hFF);
            if (prev_stall) begin
                chk(int'(iss_lane_vld) == snap_vld, "R8", "lane valid held", int'(iss_lane_vld), snap_vld);
                for (int k = 0; k < LANES; k++)
                    chk(lane_idx(k) == snap_idx[k], "R8", "index held", lane_idx(k), snap_idx[k]);
            end
            for (int k = 0; k < LANES; k++) begin
                bit ev;
                ev = (k < grp);
                chk(iss_lane_vld[k] == ev, "R3", $sformatf("lane %0d valid", k),
                    int'(iss_lane_vld[k]), int'(ev));
                if (ev) begin
                    int e;
                    e = el[ptr + k];
                    chk(lane_idx(k) == e, req, $sformatf("lane %0d index", k), lane_idx(k), e);
                    chk(lane_reg(iss_rd, k) == exp_reg(rd, vd, e), "R4", "rd",
                        lane_reg(iss_rd, k), exp_reg(rd, vd, e));
                    chk(lane_reg(iss_rs1, k) == exp_reg(rs1, v1, e), "R4", "rs1",
                        lane_reg(iss_rs1, k), exp_reg(rs1, v1, e));
                    chk(lane_reg(iss_rs2, k) == exp_reg(rs2, v2, e), "R4", "rs2",
                        lane_reg(iss_rs2, k), exp_reg(rs2, v2, e));
                end
                snap_idx[k] = lane_idx(k);
            end
            snap_vld = int'(iss_lane_vld);
            if (rdy) ptr += grp;
            prev_stall = !rdy;
            cyc++;
            @(negedge clk);
        end
        iss_ready = 1'b0;
        #1;
        chk(ptr == n, req, "elements drained", ptr, n);
        chk(iss_valid == 1'b0, (n == 0) ? "R6" : "R2", "no issue after last element",
            int'(iss_valid), 0);
        chk(in_ready == 1'b1, (n == 0) ? "R6" : "R7", "in_ready after op", int'(in_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        chk(iss_valid == 1'b0, "R1", "iss_valid in reset", int'(iss_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(in_ready == 1'b1 && iss_valid == 1'b0, "R1", "state after reset",
            int'({in_ready, iss_valid}), 2);

        // R2, R3, R4: every mask at full length, rs1 wraps past register 31
        for (int m = 0; m < 256; m++)
            run_op(m ^ 8'h5A, 3, 30, 7, 1'b1, 1'b1, 1'b0, XLEN, m, 1'b0, "R2");

        // R2, R8: every length with a full mask, with stalls
        for (int v = 0; v <= XLEN; v++)
            run_op(16 + v, 9, 2, 28, 1'b1, 1'b0, 1'b1, v, 8'hFF, 1'b1, "R2");

        // R2, R8: sparse masks with stalls
        run_op(8'hA1, 0, 31, 4, 1'b0, 1'b1, 1'b1, XLEN, 8'hB5, 1'b1, "R2");
        run_op(8'hA2, 5, 6, 7, 1'b1, 1'b1, 1'b1, 7, 8'hC3, 1'b1, "R2");

        // R9: length beyond XLEN is clamped
        run_op(8'h33, 1, 1, 1, 1'b1, 1'b1, 1'b1, 12, 8'hF7, 1'b0, "R9");
        run_op(8'h34, 4, 4, 4, 1'b0, 1'b1, 1'b0, 15, 8'h81, 1'b0, "R9");

        // R5: all-scalar operations issue element 0 once
        run_op(8'h40, 12, 13, 14, 1'b0, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R5");
        run_op(8'h41, 12, 13, 14, 1'b0, 1'b0, 1'b0, 5, 8'hAA, 1'b1, "R5");
        run_op(8'h42, 31, 0, 17, 1'b0, 1'b0, 1'b0, XLEN, 8'hFF, 1'b0, "R5");

        // R6: nothing enabled
        run_op(8'h50, 2, 3, 4, 1'b1, 1'b0, 1'b0, 0, 8'hFF, 1'b0, "R6");
        run_op(8'h51, 2, 3, 4, 1'b0, 0, 1'b1, 3, 8'hF8, 1'b0, "R6");

        // R7: final group and the next operation in the same cycle
        @(negedge clk);
        put_inputs(8'h61, 0, 0, 0, 1'b1, 1'b1, 1'b1, XLEN, 8'h3F);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        iss_ready = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R7", "in_ready with remainder pending", int'(in_ready), 0);
        chk(int'(iss_lane_vld) == 15, "R3", "first group lanes", int'(iss_lane_vld), 15);
        chk(lane_idx(3) == 3, "R3", "first group lane 3 index", lane_idx(3), 3);
        @(negedge clk);
        put_inputs(8'h62, 10, 0, 0, 1'b1, 1'b0, 1'b0, XLEN, 8'h81);
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R7", "in_ready on final group", int'(in_ready), 1);
        chk(int'(iss_lane_vld) == 3, "R3", "final group lanes", int'(iss_lane_vld), 3);
        chk(lane_idx(0) == 4 && lane_idx(1) == 5, "R3", "final group indices",
            lane_idx(0) * 10 + lane_idx(1), 45);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(iss_valid == 1'b1, "R7", "next op issues without gap", int'(iss_valid), 1);
        chk(int'(iss_op) == 8'h62, "R7", "next op opcode", int'(iss_op), 8'h62);
        chk(lane_idx(0) == 0 && lane_idx(1) == 7, "R7", "next op indices",
            lane_idx(0) * 10 + lane_idx(1), 7);
        chk(lane_reg(iss_rd, 1) == 17, "R4", "next op rd lane 1", lane_reg(iss_rd, 1), 17);
        @(negedge clk);
        iss_ready = 1'b0;
        #1;
        chk(iss_valid == 1'b0 && in_ready == 1'b1, "R7", "idle after next op",
            int'({iss_valid, in_ready}), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule